// File: doc/BRIEF.md
# UART Transmit Section with Control/Status Register

This block is the sending half of a UART. Software (or a DMA controller) places a byte into a one-byte holding buffer. At the next bit-time tick after the serial shifter has gone idle, and only while sending is enabled, the byte moves into the shifter. The shifter then sends it as an asynchronous frame on the serial output. A free-running, down-counting baud counter sets the bit time. It reloads from a programmable 16-bit divisor each time it reaches zero, and each reload is one bit-time tick.

A single byte-wide control/status register holds two command bits and two status bits. The command bits are send enable and DMA enable. The status bits are the buffer-empty flag and a sticky zero-count flag, and the two status bits behave differently. The buffer-empty flag comes out of reset set. The zero-count flag is cleared only by writing a one to its position. When DMA is enabled and the buffer is empty, the block asks an external DMA controller for a byte. The controller answers with an acknowledge strobe that carries the byte. An echo selector can hand the serial pin to an outside source whatever the enable state.

Top module: `uart_tx_section`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x02, `txd` is 1 and `dma_req` is 0.
- R2: `dma_req` is high exactly when the DMA-enable bit (bit 0 of address 0) is 1 and the buffer-empty flag is 1. After a cycle with `dma_ack` high, `dma_req` is low.
- R3: A write to address 1, or a cycle with `dma_ack` high, stores a byte in the holding buffer and clears the buffer-empty flag (bit 1) at the next edge. If both occur in the same cycle, the register-bus byte is the one kept. Bit 1 is read-only.
- R4: The zero-count flag (bit 2) becomes 1 on the edge at which the baud counter is at zero, and stays 1. Writing address 0 with bit 2 = 1 clears it, and writing bit 2 = 0 leaves it unchanged. If a clearing write meets a zero count in the same cycle, the flag stays 1.
- R5: While send enable (bit 3) is 0 and echo is off, `txd` is 1 and no byte leaves the holding buffer, so the empty flag stays 0.
- R6: While `echo_mode` is 1, `txd` equals `echo_in` in the same cycle, whatever the state of send enable and of the shifter.
- R7: A frame is a 0 start bit, 8 data bits with the LSB first, and a 1 stop bit. Each bit lasts divisor+1 clock cycles and begins on the cycle after a tick.
- R8: The baud counter counts down and reloads from the divisor at zero. The divisor low byte is at address 2 and the high byte at address 3, and the reset value is RESET_DIV. A divisor write takes effect at the next reload.
- R9: A byte moves from the buffer to the shifter on the first tick at which the shifter is idle, send enable is 1 and the buffer is full. At that edge the empty flag sets, unless a new byte is written in the same cycle. In that case the shifter takes the old byte, and the buffer keeps the new byte with the flag at 0.
- R10: Address 0 reads {4'b0, enable, zero-count, empty, DMA enable}, so bits 7:4 always read 0. Address 1 reads the holding byte. Addresses 2 and 3 read back the divisor bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| dma_req | output | 1 | Request to the DMA controller for a byte |
| dma_ack | input | 1 | DMA strobe; writes dma_data into the buffer |
| dma_data | input | 8 | Byte delivered with dma_ack |
| echo_mode | input | 1 | Selects echo_in as the serial output |
| echo_in | input | 1 | Echo source |
| txd | output | 1 | Serial transmit line |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the buffer-to-shifter transfer meets a fresh buffer write. The bench waits until its reference model shows the counter at zero with the shifter idle and the buffer full, and writes a new byte in exactly that cycle. The sent frame must carry the old byte, and the buffer must hold the new byte with the empty flag low. In the second, a zero-count clear meets a counter reload. The clearing write is aimed at a reload cycle, and the flag must read 1 afterwards. A reference model compares the serial line, the request and the register read data on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int DIV_W      = 2 * BYTE_W;          // divisor spans two register bytes
    localparam int FRAME_BITS = BYTE_W + 2;          // start + data + stop
    localparam int BITIDX_W   = $clog2(FRAME_BITS);

    // bit positions inside the control/status byte
    localparam int POS_DMA   = 0;
    localparam int POS_EMPTY = 1;
    localparam int POS_ZERO  = 2;
    localparam int POS_TXEN  = 3;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_HOLD   = 2'd1,
        ADDR_DIV_LO = 2'd2,
        ADDR_DIV_HI = 2'd3
    } reg_addr_e;

    // packed so that its bit order matches the POS_* positions
    typedef struct packed {
        logic tx_en;
        logic zero_cnt;
        logic buf_empty;
        logic dma_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{tx_en: 1'b0, zero_cnt: 1'b0, buf_empty: 1'b1, dma_en: 1'b0};

    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [BYTE_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
        return {{(BYTE_W-$bits(ctrl_t)){1'b0}}, c};
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud
    import uart_tx_pkg::*;
#(
    parameter int RESET_DIV = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= DIV_W'(RESET_DIV);
        end else if (tick) begin
            cnt_q <= divisor;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              idle,
    output logic              line
);

    localparam logic [BITIDX_W-1:0] LAST_IDX = BITIDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sh_q;
    logic [BITIDX_W-1:0]   idx_q;
    logic                  busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            sh_q   <= make_frame(byte_in);
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (tick && busy_q) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idle = !busy_q;
    assign line = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/utx_regs.sv
module utx_regs
    import uart_tx_pkg::*;
#(
    parameter int RESET_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              dma_ack,
    input  logic [BYTE_W-1:0] dma_data,
    input  logic              tick,
    input  logic              shifter_idle,
    output logic              load,
    output logic [BYTE_W-1:0] hold_byte,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  divisor
);

    reg_addr_e         sel;
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] hold_q;
    logic [DIV_W-1:0]  div_q;
    logic              wr_ctrl, wr_hold, wr_lo, wr_hi, fill;

    assign sel     = reg_addr_e'(addr);
    assign wr_ctrl = wr_en && (sel == ADDR_CTRL);
    assign wr_hold = wr_en && (sel == ADDR_HOLD);
    assign wr_lo   = wr_en && (sel == ADDR_DIV_LO);
    assign wr_hi   = wr_en && (sel == ADDR_DIV_HI);
    assign fill    = wr_hold || dma_ack;

    assign load = tick && shifter_idle && ctrl_q.tx_en && !ctrl_q.buf_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            hold_q <= '0;
            div_q  <= DIV_W'(RESET_DIV);
        end else begin
            if (wr_ctrl) begin
                ctrl_q.tx_en  <= wdata[POS_TXEN];
                ctrl_q.dma_en <= wdata[POS_DMA];
            end
            // a reload in the same cycle outranks the clearing write
            if (tick) begin
                ctrl_q.zero_cnt <= 1'b1;
            end else if (wr_ctrl && wdata[POS_ZERO]) begin
                ctrl_q.zero_cnt <= 1'b0;
            end
            // register bus outranks the DMA strobe
            if (wr_hold) begin
                hold_q <= wdata;
            end else if (dma_ack) begin
                hold_q <= dma_data;
            end
            if (fill) begin
                ctrl_q.buf_empty <= 1'b0;
            end else if (load) begin
                ctrl_q.buf_empty <= 1'b1;
            end
            if (wr_lo) begin
                div_q[BYTE_W-1:0] <= wdata;
            end
            if (wr_hi) begin
                div_q[DIV_W-1:BYTE_W] <= wdata;
            end
        end
    end

    always_comb begin
        unique case (sel)
            ADDR_CTRL:   rdata = pack_ctrl(ctrl_q);
            ADDR_HOLD:   rdata = hold_q;
            ADDR_DIV_LO: rdata = div_q[BYTE_W-1:0];
            ADDR_DIV_HI: rdata = div_q[DIV_W-1:BYTE_W];
            default:     rdata = '0;
        endcase
    end

    assign hold_byte = hold_q;
    assign ctrl      = ctrl_q;
    assign divisor   = div_q;

endmodule

// File: rtl/uart_tx_section.sv
module uart_tx_section
    import uart_tx_pkg::*;
#(
    parameter int RESET_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic [BYTE_W-1:0] dma_data,
    input  logic              echo_mode,
    input  logic              echo_in,
    output logic              txd
);

    logic              baud_tick;
    logic              xfer_load;
    logic              sh_idle;
    logic              sh_line;
    logic [BYTE_W-1:0] hold_byte;
    logic [DIV_W-1:0]  divisor;
    ctrl_t             ctrl;

    utx_regs #(.RESET_DIV(RESET_DIV)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (reg_wr_en),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .dma_ack      (dma_ack),
        .dma_data     (dma_data),
        .tick         (baud_tick),
        .shifter_idle (sh_idle),
        .load         (xfer_load),
        .hold_byte    (hold_byte),
        .ctrl         (ctrl),
        .divisor      (divisor)
    );

    utx_baud #(.RESET_DIV(RESET_DIV)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (baud_tick)
    );

    utx_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .load    (xfer_load),
        .byte_in (hold_byte),
        .idle    (sh_idle),
        .line    (sh_line)
    );

    assign dma_req = ctrl.dma_en && ctrl.buf_empty;

    always_comb begin
        if (echo_mode) begin
            txd = echo_in;
        end else if (ctrl.tx_en) begin
            txd = sh_line;
        end else begin
            txd = 1'b1;
        end
    end

endmodule

// File: rtl/utx_checker.sv
module utx_checker
    import uart_tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] wdata,
    input logic              dma_ack,
    input logic              dma_req,
    input logic              tick,
    input logic              load,
    input ctrl_t             ctrl,
    input logic              sh_idle,
    input logic              sh_line,
    input logic [DIV_W-1:0]  divisor
);

    logic fill;
    logic zero_clear;

    assign fill       = (wr_en && addr == 2'd1) || dma_ack;
    assign zero_clear = wr_en && addr == 2'd0 && wdata[POS_ZERO];

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst) dma_ack |=> !dma_req); // R2
    AST_FILL_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst) fill |=> !ctrl.buf_empty); // R3
    AST_ZERO_LATCHES: assert property (@(posedge clk) disable iff (rst) tick |=> ctrl.zero_cnt); // R4
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst) (ctrl.zero_cnt && !zero_clear) |=> ctrl.zero_cnt); // R4
    AST_NO_XFER_DISABLED: assert property (@(posedge clk) disable iff (rst) (!ctrl.tx_en && !fill) |=> (ctrl.buf_empty == $past(ctrl.buf_empty))); // R5
    AST_START_BIT: assert property (@(posedge clk) disable iff (rst) load |=> (!sh_idle && sh_line == 1'b0)); // R7
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst) (tick && divisor != '0) |=> !tick); // R8

endmodule

bind uart_tx_section utx_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .dma_ack (dma_ack),
    .dma_req (dma_req),
    .tick    (baud_tick),
    .load    (xfer_load),
    .ctrl    (ctrl),
    .sh_idle (sh_idle),
    .sh_line (sh_line),
    .divisor (divisor)
);

// File: tb/uart_tx_section_bench.sv
module uart_tx_section_bench;

    localparam int RST_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dma_req;
    logic       dma_ack = 1'b0;
    logic [7:0] dma_data = 8'h00;
    logic       echo_mode = 1'b0;
    logic       echo_in = 1'b0;
    logic       txd;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    bit    dma_auto = 1'b0;
    int    dma_cnt = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_dma_en, m_tx_en, m_zc, m_empty;
    bit [7:0] m_buf;
    int       m_div, m_cnt;
    bit       m_q[$];

    uart_tx_section u_uart_tx_section (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_req   (dma_req),
        .dma_ack   (dma_ack),
        .dma_data  (dma_data),
        .echo_mode (echo_mode),
        .echo_in   (echo_in),
        .txd       (txd)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // model: outputs from model state and current inputs
    function automatic bit m_txd();
        if (echo_mode) return echo_in;
        if (!m_tx_en) return 1'b1;
        return (m_q.size() > 0) ? m_q[0] : 1'b1;
    endfunction

    function automatic int m_rdata();
        case (reg_addr)
            2'd0: return {4'b0, m_tx_en, m_zc, m_empty, m_dma_en};
            2'd1: return m_buf;
            2'd2: return m_div & 8'hFF;
            default: return (m_div >> 8) & 8'hFF;
        endcase
    endfunction

    // model: state update
    always @(posedge clk) begin
        bit tick, ld;
        bit [7:0] old_buf;
        if (rst) begin
            m_dma_en = 0; m_tx_en = 0; m_zc = 0; m_empty = 1;
            m_buf = 0; m_div = RST_DIV; m_cnt = RST_DIV;
            m_q.delete();
        end else begin
            tick    = (m_cnt == 0);
            ld      = tick && (m_q.size() == 0) && m_tx_en && !m_empty;
            old_buf = m_buf;
            m_cnt   = tick ? m_div : m_cnt - 1;
            if (tick) begin
                if (m_q.size() > 0) void'(m_q.pop_front());
                else if (ld) begin
                    m_q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_q.push_back(old_buf[i]);
                    m_q.push_back(1'b1);
                end
            end
            if (tick) m_zc = 1;
            else if (reg_wr_en && reg_addr == 2'd0 && reg_wdata[2]) m_zc = 0;
            if (reg_wr_en && reg_addr == 2'd0) begin
                m_tx_en  = reg_wdata[3];
                m_dma_en = reg_wdata[0];
            end
            if (reg_wr_en && reg_addr == 2'd1) m_buf = reg_wdata;
            else if (dma_ack) m_buf = dma_data;
            if ((reg_wr_en && reg_addr == 2'd1) || dma_ack) m_empty = 0;
            else if (ld) m_empty = 1;
            if (reg_wr_en && reg_addr == 2'd2) m_div = (m_div & 32'hFF00) | reg_wdata;
            if (reg_wr_en && reg_addr == 2'd3) m_div = (m_div & 32'h00FF) | (int'(reg_wdata) << 8);
        end
    end

    // per-cycle comparison, away from the edges
    always @(negedge clk) begin
        #3;
        if (cmp_on && !rst && !done) begin
            check(cur_req, "txd", txd, m_txd());
            check(cur_req, "dma_req", dma_req, m_dma_en && m_empty); // R2
            check(cur_req, "rdata", reg_rdata, m_rdata());
        end
    end

    // DMA responder
    always @(negedge clk) begin
        if (dma_auto) begin
            if (dma_req && !dma_ack) begin
                dma_ack  = 1'b1;
                dma_data = 8'h10 + 8'(dma_cnt * 37);
                dma_cnt++;
            end else begin
                dma_ack = 1'b0;
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #3;
        check("R1", "ctl", reg_rdata, 8'h02);
        check("R1", "txd", txd, 1);
        check("R1", "dma_req", dma_req, 0);
        @(negedge clk);
        cmp_on = 1'b1;

        // R8: program divisor 4
        cur_req = "R8";
        bus_wr(2'd2, 8'h04);
        bus_wr(2'd3, 8'h00);
        repeat (20) @(negedge clk);

        // R4: write 0 keeps, write 1 clears, reload outranks clear
        cur_req = "R4";
        bus_wr(2'd0, 8'h00);
        #3 check("R4", "zc kept by write 0", reg_rdata[2], 1);
        @(negedge clk);
        while (m_cnt == 0) @(negedge clk);
        bus_wr(2'd0, 8'h04);
        #3 check("R4", "zc cleared", reg_rdata[2], m_cnt == 4 ? 1 : 0);
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
        bus_wr(2'd0, 8'h04);
        #3 check("R4", "zc set beats clear", reg_rdata[2], 1);
        @(negedge clk);

        // R5: byte waits while disabled
        cur_req = "R5";
        bus_wr(2'd1, 8'hA5);
        for (int i = 0; i < 30; i++) begin
            #3;
            check("R5", "txd idle", txd, 1);
            check("R3", "empty cleared", reg_rdata[1], 0);
            @(negedge clk);
        end

        // R7: send the frame
        cur_req = "R7";
        bus_wr(2'd0, 8'h08);
        repeat (70) @(negedge clk);
        check("R9", "empty after transfer", m_empty, 1);

        // R9: write coinciding with the transfer
        cur_req = "R9";
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h3C);
        bus_wr(2'd0, 8'h08);
        while (!(m_cnt == 0 && m_q.size() == 0)) @(negedge clk);
        bus_wr(2'd1, 8'hC3);
        #3 check("R9", "empty stays 0", reg_rdata[1], 0);
        @(negedge clk);
        reg_addr = 2'd1;
        #3 check("R9", "buffer keeps new byte", reg_rdata, 8'hC3);
        @(negedge clk);
        reg_addr = 2'd0;
        repeat (130) @(negedge clk);

        // R2: DMA-fed transmission
        cur_req = "R2";
        dma_auto = 1'b1;
        bus_wr(2'd0, 8'h09);
        repeat (200) @(negedge clk);
        dma_auto = 1'b0;
        @(negedge clk);
        dma_ack = 1'b0;
        repeat (130) @(negedge clk);
        check("R2", "dma bytes taken", dma_cnt >= 3, 1);

        // R3: CPU and DMA write in the same cycle
        cur_req = "R3";
        bus_wr(2'd0, 8'h01);
        #3 check("R2", "req with empty buffer", dma_req, 1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h5A;
        dma_ack = 1'b1; dma_data = 8'h77;
        @(negedge clk);
        reg_wr_en = 1'b0; dma_ack = 1'b0;
        #3 check("R3", "cpu byte wins", reg_rdata, 8'h5A);
        @(negedge clk);
        reg_addr = 2'd0;

        // R6: echo overrides disabled and active line
        cur_req = "R6";
        echo_mode = 1'b1;
        for (int i = 0; i < 12; i++) begin
            echo_in = i[0] ^ i[2];
            #3 check("R6", "echo tx off", txd, echo_in);
            @(negedge clk);
        end
        bus_wr(2'd0, 8'h08);
        for (int i = 0; i < 40; i++) begin
            echo_in = i[1];
            #3 check("R6", "echo tx on", txd, echo_in);
            @(negedge clk);
        end
        echo_mode = 1'b0;
        repeat (40) @(negedge clk);

        // R10: register map readback
        cur_req = "R10";
        bus_wr(2'd0, 8'hF8);
        #3 check("R10", "upper bits zero", reg_rdata[7:4], 0);
        @(negedge clk);
        bus_wr(2'd3, 8'h01);
        reg_addr = 2'd3;
        #3 check("R10", "div hi", reg_rdata, 8'h01);
        @(negedge clk);
        reg_addr = 2'd2;
        #3 check("R10", "div lo", reg_rdata, 8'h04);
        @(negedge clk);
        reg_addr = 2'd0;

        // R8: shorter divisor, taken at next reload
        cur_req = "R8";
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd2, 8'h01);
        repeat (300) @(negedge clk);
        bus_wr(2'd1, 8'h96);
        cur_req = "R7";
        repeat (40) @(negedge clk);

        finish_run();
    end

endmodule